// File: doc/BRIEF.md
# Pending Trap Arbiter with Entry Sequencer

This block keeps one pending flag and one cause code for each trap number of a processor. Each cycle it looks at the flags from trap number 1 upward. It skips any trap whose mask condition in the current machine state word blocks it, and it takes the first trap that remains. Taking a trap is a single registered step. The block saves a return address and a status word that carries the trap's cause bits. It builds the new machine state word with the mode bits cleared, computes the handler address, and clears the taken flag. A one-cycle pulse tells the address translation side to flush.

Each trap class decides two things. It decides whether the saved address is the current or the next instruction. It also decides which cause bits go into the saved status word. A machine-check trap taken while machine-check enable is off raises a fatal flag in the same cycle as its entry.

Top module: `trap_entry_arbiter`

## Requirements
- R1: After reset every pending flag is clear, and `flush_o`, `fatal_o`, `taken_num_o`, `vector_o`, `srr0_o`, `srr1_o` and `msr_o` are all zero.
- R2: A strobe on `raise_vld_i[n]` for n >= 1 marks trap n pending with cause code `raise_code_i[n*CODE_W +: CODE_W]`. A strobe on index 0 is ignored and never leads to an entry.
- R3: Of the eligible pending traps, the lowest number is taken. A strobe sampled at clock edge k can be taken at edge k+1. `flush_o` is high for exactly the cycle after the taking edge, and `taken_num_o` then shows the trap number. The taken flag clears at that same edge, so at most one trap is taken per cycle.
- R4: Traps 5 (external) and 9 (decrementer) are not eligible while `msr_i[15]` is 0. They stay pending and are taken once the bit is 1. Higher-numbered traps are taken past them while they are masked.
- R5: Trap 7 (program) with cause code 0 (floating point) is not eligible while `msr_i[11]` and `msr_i[8]` are both 0. It stays pending.
- R6: `vector_o` equals the trap number shifted left by 8. For trap 1 with `msr_i[6]` set, 0xFFC00 is added to that value.
- R7: `srr0_o` takes `next_pc_i` for traps 4, 5, 9, 12 and 13. It takes `cur_pc_i` for every other trap.
- R8: For trap 4 (fetch fault), `srr1_o` is `msr_i` ORed with a cause bit: 0x40000000 for code 0 (translation miss), 0x10000000 for code 1 (no-execute or guarded), and 0x08000000 for any other code.
- R9: For trap 7, `srr1_o` is the low 16 bits of `msr_i`, ORed with 0x00010000, and ORed with a cause bit: 0x00100000 for code 0, 0x00080000 for code 1 (illegal), 0x00040000 for code 2 (privileged), 0x00020000 for code 3 (trap). Other codes add no cause bit.
- R10: For every trap other than 4 and 7, `srr1_o` equals `msr_i`.
- R11: `msr_o` is `msr_i` with bits 18, 15, 14, 13, 11, 10, 9, 8, 5, 4 and 1 cleared, and bit 0 loaded from bit 16. All other bits are kept.
- R12: Trap 2 (machine check) also clears bit 12 in `msr_o`. If `msr_i[12]` was 0 when the trap was taken, `fatal_o` is high together with that entry's `flush_o`. `fatal_o` is low in every other cycle.
- R13: If trap n is taken at the same edge that samples a new strobe for n, the flag stays set with the new code, and trap n is taken again later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_vld_i | input | NUM_EXC | One raise strobe per trap number |
| raise_code_i | input | NUM_EXC*CODE_W | Cause code per trap number, packed by index |
| msr_i | input | 32 | Current machine state word |
| cur_pc_i | input | ADDR_W | Address of the current instruction |
| next_pc_i | input | ADDR_W | Address of the next instruction |
| flush_o | output | 1 | One-cycle entry and translation flush pulse |
| fatal_o | output | 1 | Machine check taken with its enable off |
| taken_num_o | output | log2(NUM_EXC) | Number of the trap last taken |
| vector_o | output | ADDR_W | Handler address of the last entry |
| srr0_o | output | ADDR_W | Saved return address |
| srr1_o | output | 32 | Saved status word with cause bits |
| msr_o | output | 32 | Machine state word for the handler |

## Verification
Two situations are hard to produce from the ports. The first is a strobe for a trap landing on the very edge that takes that same trap. The second is a masked external or decrementer trap held pending while higher-numbered traps are taken past it. Directed sequences set up both: one re-strobes a trap in the cycle it is being taken, and another holds the enable bit low across several entries before raising it. After that, a long random run flips the machine state word on every cycle. This catches the floating-point program mask and the machine-check enable in both states, against a cycle-level model in the bench.

// File: rtl/trap_pkg.sv
package trap_pkg;
   // machine state word bit positions
   localparam int unsigned MB_LE  = 0;
   localparam int unsigned MB_RI  = 1;
   localparam int unsigned MB_DR  = 4;
   localparam int unsigned MB_IR  = 5;
   localparam int unsigned MB_IP  = 6;
   localparam int unsigned MB_FE1 = 8;
   localparam int unsigned MB_BE  = 9;
   localparam int unsigned MB_SE  = 10;
   localparam int unsigned MB_FE0 = 11;
   localparam int unsigned MB_ME  = 12;
   localparam int unsigned MB_FP  = 13;
   localparam int unsigned MB_PR  = 14;
   localparam int unsigned MB_EE  = 15;
   localparam int unsigned MB_ILE = 16;
   localparam int unsigned MB_POW = 18;

   localparam logic [31:0] MSR_ENTRY_CLR =
      (32'd1 << MB_POW) | (32'd1 << MB_EE) | (32'd1 << MB_PR) | (32'd1 << MB_FP) |
      (32'd1 << MB_FE0) | (32'd1 << MB_SE) | (32'd1 << MB_BE) | (32'd1 << MB_FE1) |
      (32'd1 << MB_IR)  | (32'd1 << MB_DR) | (32'd1 << MB_RI) | (32'd1 << MB_LE);

   // trap numbers
   localparam int unsigned EXN_RESET  = 1;
   localparam int unsigned EXN_MCHK   = 2;
   localparam int unsigned EXN_DACC   = 3;
   localparam int unsigned EXN_IFETCH = 4;
   localparam int unsigned EXN_EXT    = 5;
   localparam int unsigned EXN_ALIGN  = 6;
   localparam int unsigned EXN_PROG   = 7;
   localparam int unsigned EXN_FPU    = 8;
   localparam int unsigned EXN_DEC    = 9;
   localparam int unsigned EXN_SYSC   = 12;
   localparam int unsigned EXN_TRACE  = 13;

   // saved status cause bits
   localparam logic [31:0] ST_FETCH_MISS   = 32'h4000_0000;
   localparam logic [31:0] ST_FETCH_NOEXEC = 32'h1000_0000;
   localparam logic [31:0] ST_FETCH_OTHER  = 32'h0800_0000;
   localparam logic [31:0] ST_PROG_FP      = 32'h0010_0000;
   localparam logic [31:0] ST_PROG_ILL     = 32'h0008_0000;
   localparam logic [31:0] ST_PROG_PRIV    = 32'h0004_0000;
   localparam logic [31:0] ST_PROG_TRAP    = 32'h0002_0000;
   localparam logic [31:0] ST_PROG_ANY     = 32'h0001_0000;

   localparam logic [31:0] RESET_HI_OFS    = 32'h000F_FC00;

   function automatic logic resumes_next(input int unsigned n);
      return (n == EXN_IFETCH) || (n == EXN_EXT) || (n == EXN_DEC) ||
             (n == EXN_SYSC) || (n == EXN_TRACE);
   endfunction
endpackage

// File: rtl/trap_pend_store.sv
module trap_pend_store #(
   parameter int unsigned NUM_EXC = 16,
   parameter int unsigned CODE_W  = 4,
   localparam int unsigned IDX_W  = $clog2(NUM_EXC)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_EXC-1:0]        raise_vld,
   input  logic [NUM_EXC*CODE_W-1:0] raise_code,
   input  logic                      take_vld,
   input  logic [IDX_W-1:0]          take_idx,
   output logic [NUM_EXC-1:0]        pend,
   output logic [NUM_EXC*CODE_W-1:0] pend_code
);
   generate
      for (genvar i = 0; i < NUM_EXC; i++) begin : g_slot
         if (i == 0) begin : g_rsvd
            // slot 0 is never scanned; its strobe is dropped
            logic unused_slot0;
            assign unused_slot0 = ^{raise_vld[0], raise_code[CODE_W-1:0]};
            assign pend[0] = 1'b0;
            assign pend_code[CODE_W-1:0] = '0;
         end else begin : g_live
            logic              bit_q;
            logic [CODE_W-1:0] code_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  bit_q  <= 1'b0;
                  code_q <= '0;
               end else if (raise_vld[i]) begin
                  // a new strobe wins over a take in the same cycle
                  bit_q  <= 1'b1;
                  code_q <= raise_code[i*CODE_W +: CODE_W];
               end else if (take_vld && (take_idx == IDX_W'(i))) begin
                  bit_q  <= 1'b0;
               end
            end
            assign pend[i] = bit_q;
            assign pend_code[i*CODE_W +: CODE_W] = code_q;
         end
      end
   endgenerate
endmodule

// File: rtl/trap_pick.sv
module trap_pick
   import trap_pkg::*;
#(
   parameter int unsigned NUM_EXC = 16,
   parameter int unsigned CODE_W  = 4,
   localparam int unsigned IDX_W  = $clog2(NUM_EXC)
) (
   input  logic [NUM_EXC-1:0]        pend,
   input  logic [NUM_EXC*CODE_W-1:0] pend_code,
   input  logic                      ext_en,
   input  logic                      fp_mode0,
   input  logic                      fp_mode1,
   output logic                      hit,
   output logic [IDX_W-1:0]          idx,
   output logic [CODE_W-1:0]         code
);
   logic [NUM_EXC-1:0] elig;

   generate
      for (genvar i = 0; i < NUM_EXC; i++) begin : g_elig
         if (i == EXN_EXT || i == EXN_DEC) begin : g_ee
            assign elig[i] = pend[i] & ext_en;
         end else if (i == EXN_PROG) begin : g_prog
            assign elig[i] = pend[i] &
               ((pend_code[i*CODE_W +: CODE_W] != '0) | fp_mode0 | fp_mode1);
         end else begin : g_plain
            assign elig[i] = pend[i];
         end
      end
   endgenerate

   // downward walk: the last assignment (lowest index) wins
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = NUM_EXC - 1; i >= 0; i--) begin
         if (elig[i]) begin
            hit = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end

   assign code = pend_code[idx*CODE_W +: CODE_W];
endmodule

// File: rtl/trap_entry_calc.sv
module trap_entry_calc
   import trap_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned CODE_W      = 4,
   parameter int unsigned IDX_W       = 4,
   parameter bit          RESET_HI_EN = 1'b1
) (
   input  logic [IDX_W-1:0]  num,
   input  logic [CODE_W-1:0] code,
   input  logic [31:0]       msr,
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic [ADDR_W-1:0] next_pc,
   output logic [ADDR_W-1:0] srr0,
   output logic [ADDR_W-1:0] vector,
   output logic [31:0]       srr1,
   output logic [31:0]       msr_new,
   output logic              fatal
);
   localparam logic [IDX_W-1:0]  N_RESET  = IDX_W'(EXN_RESET);
   localparam logic [IDX_W-1:0]  N_MCHK   = IDX_W'(EXN_MCHK);
   localparam logic [IDX_W-1:0]  N_IFETCH = IDX_W'(EXN_IFETCH);
   localparam logic [IDX_W-1:0]  N_PROG   = IDX_W'(EXN_PROG);
   localparam logic [CODE_W-1:0] C0 = CODE_W'(0);
   localparam logic [CODE_W-1:0] C1 = CODE_W'(1);
   localparam logic [CODE_W-1:0] C2 = CODE_W'(2);
   localparam logic [CODE_W-1:0] C3 = CODE_W'(3);

   logic hi_ofs;

   generate
      if (RESET_HI_EN) begin : g_hi
         assign hi_ofs = (num == N_RESET) && msr[MB_IP];
      end else begin : g_nohi
         assign hi_ofs = 1'b0;
      end
   endgenerate

   always_comb begin
      srr0   = resumes_next(int'(num)) ? next_pc : cur_pc;
      vector = ADDR_W'({num, 8'h00});
      if (hi_ofs) vector = vector + ADDR_W'(RESET_HI_OFS);

      srr1 = msr;
      if (num == N_IFETCH) begin
         if (code == C0)      srr1 = msr | ST_FETCH_MISS;
         else if (code == C1) srr1 = msr | ST_FETCH_NOEXEC;
         else                 srr1 = msr | ST_FETCH_OTHER;
      end else if (num == N_PROG) begin
         srr1 = {16'h0000, msr[15:0]} | ST_PROG_ANY;
         if (code == C0)      srr1 = srr1 | ST_PROG_FP;
         else if (code == C1) srr1 = srr1 | ST_PROG_ILL;
         else if (code == C2) srr1 = srr1 | ST_PROG_PRIV;
         else if (code == C3) srr1 = srr1 | ST_PROG_TRAP;
      end

      msr_new         = msr & ~MSR_ENTRY_CLR;
      msr_new[MB_LE]  = msr[MB_ILE];
      fatal           = 1'b0;
      if (num == N_MCHK) begin
         msr_new[MB_ME] = 1'b0;
         fatal          = ~msr[MB_ME];
      end
   end
endmodule

// File: rtl/trap_entry_arbiter.sv
module trap_entry_arbiter
   import trap_pkg::*;
#(
   parameter int unsigned NUM_EXC     = 16,
   parameter int unsigned CODE_W      = 4,
   parameter int unsigned ADDR_W      = 32,
   parameter bit          RESET_HI_EN = 1'b1,
   localparam int unsigned IDX_W      = $clog2(NUM_EXC)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_EXC-1:0]        raise_vld_i,
   input  logic [NUM_EXC*CODE_W-1:0] raise_code_i,
   input  logic [31:0]               msr_i,
   input  logic [ADDR_W-1:0]         cur_pc_i,
   input  logic [ADDR_W-1:0]         next_pc_i,
   output logic                      flush_o,
   output logic                      fatal_o,
   output logic [IDX_W-1:0]          taken_num_o,
   output logic [ADDR_W-1:0]         vector_o,
   output logic [ADDR_W-1:0]         srr0_o,
   output logic [31:0]               srr1_o,
   output logic [31:0]               msr_o
);
   generate
      if (NUM_EXC < EXN_TRACE + 1 || NUM_EXC > 64) begin : g_bad_num
         $error("NUM_EXC must hold every trap number and stay small");
      end
      if (CODE_W < 2) begin : g_bad_code
         $error("CODE_W must carry at least four cause codes");
      end
      if (ADDR_W < IDX_W + 8 || ADDR_W < 20) begin : g_bad_addr
         $error("ADDR_W too narrow for handler addresses");
      end
   endgenerate

   logic [NUM_EXC-1:0]        pend_q;
   logic [NUM_EXC*CODE_W-1:0] pend_code;
   logic                      sel_hit;
   logic [IDX_W-1:0]          sel_idx;
   logic [CODE_W-1:0]         sel_code;
   logic [ADDR_W-1:0]         nx_srr0, nx_vec;
   logic [31:0]               nx_srr1, nx_msr;
   logic                      nx_fatal;

   trap_pend_store #(.NUM_EXC(NUM_EXC), .CODE_W(CODE_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .raise_vld  (raise_vld_i),
      .raise_code (raise_code_i),
      .take_vld   (sel_hit),
      .take_idx   (sel_idx),
      .pend       (pend_q),
      .pend_code  (pend_code)
   );

   trap_pick #(.NUM_EXC(NUM_EXC), .CODE_W(CODE_W)) u_pick (
      .pend      (pend_q),
      .pend_code (pend_code),
      .ext_en    (msr_i[MB_EE]),
      .fp_mode0  (msr_i[MB_FE0]),
      .fp_mode1  (msr_i[MB_FE1]),
      .hit       (sel_hit),
      .idx       (sel_idx),
      .code      (sel_code)
   );

   trap_entry_calc #(
      .ADDR_W(ADDR_W), .CODE_W(CODE_W), .IDX_W(IDX_W), .RESET_HI_EN(RESET_HI_EN)
   ) u_calc (
      .num     (sel_idx),
      .code    (sel_code),
      .msr     (msr_i),
      .cur_pc  (cur_pc_i),
      .next_pc (next_pc_i),
      .srr0    (nx_srr0),
      .vector  (nx_vec),
      .srr1    (nx_srr1),
      .msr_new (nx_msr),
      .fatal   (nx_fatal)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flush_o     <= 1'b0;
         fatal_o     <= 1'b0;
         taken_num_o <= '0;
         vector_o    <= '0;
         srr0_o      <= '0;
         srr1_o      <= '0;
         msr_o       <= '0;
      end else begin
         flush_o <= sel_hit;
         fatal_o <= sel_hit & nx_fatal;
         if (sel_hit) begin
            taken_num_o <= sel_idx;
            vector_o    <= nx_vec;
            srr0_o      <= nx_srr0;
            srr1_o      <= nx_srr1;
            msr_o       <= nx_msr;
         end
      end
   end
endmodule

// File: rtl/trap_entry_arbiter_chk.sv
module trap_entry_arbiter_chk
   import trap_pkg::*;
#(
   parameter int unsigned NUM_EXC = 16,
   parameter int unsigned ADDR_W  = 32,
   localparam int unsigned IDX_W  = $clog2(NUM_EXC)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_EXC-1:0] raise_vld_i,
   input logic               ee_i,
   input logic               ile_i,
   input logic [NUM_EXC-1:0] pend,
   input logic               flush_o,
   input logic               fatal_o,
   input logic [IDX_W-1:0]   taken_num_o,
   input logic [ADDR_W-1:0]  vector_o,
   input logic [31:0]        msr_o
);
   logic [NUM_EXC-1:0] raise_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raise_q <= '0;
      else        raise_q <= raise_vld_i;
   end

   AST_NO_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> (taken_num_o != '0)); // R2

   AST_TAKEN_DEQUEUED: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_o && !raise_q[taken_num_o]) |-> !pend[taken_num_o]); // R3

   AST_EE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_o && (taken_num_o == IDX_W'(EXN_EXT) || taken_num_o == IDX_W'(EXN_DEC)))
      |-> $past(ee_i)); // R4

   AST_VECTOR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_o && taken_num_o != IDX_W'(EXN_RESET))
      |-> (vector_o == ADDR_W'({taken_num_o, 8'h00}))); // R6

   AST_MODE_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> ((msr_o & MSR_ENTRY_CLR & ~32'd1) == 32'd0)); // R11

   AST_LE_FROM_ILE: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> (msr_o[MB_LE] == $past(ile_i))); // R11

   AST_FATAL_ONLY_MCHK: assert property (@(posedge clk) disable iff (!rst_n)
      fatal_o |-> (flush_o && taken_num_o == IDX_W'(EXN_MCHK))); // R12

   AST_MCHK_ME_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_o && taken_num_o == IDX_W'(EXN_MCHK)) |-> !msr_o[MB_ME]); // R12
endmodule

bind trap_entry_arbiter trap_entry_arbiter_chk #(
   .NUM_EXC(NUM_EXC), .ADDR_W(ADDR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .raise_vld_i (raise_vld_i),
   .ee_i        (msr_i[trap_pkg::MB_EE]),
   .ile_i       (msr_i[trap_pkg::MB_ILE]),
   .pend        (pend_q),
   .flush_o     (flush_o),
   .fatal_o     (fatal_o),
   .taken_num_o (taken_num_o),
   .vector_o    (vector_o),
   .msr_o       (msr_o)
);

// File: tb/trap_entry_arbiter_test.sv
module trap_entry_arbiter_test;
   localparam int CLK_PERIOD = 10;
   localparam int NUM = 16;
   localparam int CW  = 4;
   localparam int AW  = 32;

   logic clk = 1'b0;
   logic rst_n;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [NUM-1:0]    raise_vld;
   logic [NUM*CW-1:0] raise_code;
   logic [31:0]       msr, cur_pc, next_pc;
   logic              flush_o, fatal_o;
   logic [3:0]        taken_num_o;
   logic [AW-1:0]     vector_o, srr0_o;
   logic [31:0]       srr1_o, msr_o;

   trap_entry_arbiter uut (
      .clk(clk), .rst_n(rst_n), .raise_vld_i(raise_vld), .raise_code_i(raise_code),
      .msr_i(msr), .cur_pc_i(cur_pc), .next_pc_i(next_pc),
      .flush_o(flush_o), .fatal_o(fatal_o), .taken_num_o(taken_num_o),
      .vector_o(vector_o), .srr0_o(srr0_o), .srr1_o(srr1_o), .msr_o(msr_o)
   );

   int n_tests = 0;
   int n_fail  = 0;
   int n_flush = 0;
   int cnt_taken [NUM];

   bit [NUM-1:0]   m_pend;
   logic [CW-1:0]  m_code [NUM];
   logic           exp_flush, exp_fatal;
   int             exp_taken;
   logic [31:0]    exp_vec, exp_srr0, exp_srr1, exp_msr;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic bit elig(input int n, input logic [CW-1:0] c, input logic [31:0] m);
      if (n == 5 || n == 9) return m[15];
      if (n == 7 && c == 0) return m[11] | m[8];
      return 1'b1;
   endfunction

   function automatic logic [31:0] f_vec(input int n, input logic [31:0] m);
      logic [31:0] v = 32'(n) << 8;
      if (n == 1 && m[6]) v = v + 32'h000F_FC00;
      return v;
   endfunction

   function automatic logic [31:0] f_srr1(input int n, input logic [CW-1:0] c, input logic [31:0] m);
      logic [31:0] s = m;
      if (n == 4) begin
         s = m | ((c == 0) ? 32'h4000_0000 : (c == 1) ? 32'h1000_0000 : 32'h0800_0000);
      end else if (n == 7) begin
         s = (m & 32'h0000_FFFF) | 32'h0001_0000;
         case (c)
            4'd0: s = s | 32'h0010_0000;
            4'd1: s = s | 32'h0008_0000;
            4'd2: s = s | 32'h0004_0000;
            4'd3: s = s | 32'h0002_0000;
            default: ;
         endcase
      end
      return s;
   endfunction

   function automatic logic [31:0] f_msr(input int n, input logic [31:0] m);
      logic [31:0] r = (m & ~32'h0004_EF33) | {31'd0, m[16]};
      if (n == 2) r[12] = 1'b0;
      return r;
   endfunction

   task automatic model_step();
      int sel = -1;
      for (int i = 1; i < NUM; i++)
         if (sel < 0 && m_pend[i] && elig(i, m_code[i], msr)) sel = i;
      exp_flush = (sel >= 0);
      exp_fatal = 1'b0;
      if (sel >= 0) begin
         exp_taken = sel;
         exp_vec   = f_vec(sel, msr);
         exp_srr0  = (sel == 4 || sel == 5 || sel == 9 || sel == 12 || sel == 13) ? next_pc : cur_pc;
         exp_srr1  = f_srr1(sel, m_code[sel], msr);
         exp_msr   = f_msr(sel, msr);
         exp_fatal = (sel == 2) && !msr[12];
         m_pend[sel] = 1'b0;
      end
      for (int i = 1; i < NUM; i++) begin
         if (raise_vld[i]) begin
            m_pend[i] = 1'b1;
            m_code[i] = raise_code[i*CW +: CW];
         end
      end
   endtask

   task automatic compare();
      chk("R3 flush pulse", {31'd0, flush_o}, {31'd0, exp_flush});
      chk("R12 fatal flag", {31'd0, fatal_o}, {31'd0, exp_fatal});
      if (exp_flush) begin
         n_flush++;
         cnt_taken[exp_taken]++;
         chk("R3 taken number", {28'd0, taken_num_o}, 32'(exp_taken));
         chk("R6 vector", vector_o, exp_vec);
         chk("R7 saved address", srr0_o, exp_srr0);
         chk(exp_taken == 4 ? "R8 fetch status" : exp_taken == 7 ? "R9 program status" :
             "R10 plain status", srr1_o, exp_srr1);
         chk(exp_taken == 2 ? "R12 machine state" : "R11 machine state", msr_o, exp_msr);
      end
   endtask

   task automatic cycle();
      model_step();
      @(negedge clk);
      compare();
      raise_vld = '0;
   endtask

   task automatic raise(input int n, input int c);
      raise_vld[n] = 1'b1;
      raise_code[n*CW +: CW] = CW'(c);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL R3 watchdog expired act=%0d exp=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int base, b5, b9, b7, b3;
      void'($urandom(32'd20240611));
      for (int i = 0; i < NUM; i++) begin cnt_taken[i] = 0; m_code[i] = '0; end
      m_pend = '0;
      exp_flush = 1'b0; exp_fatal = 1'b0; exp_taken = 0;
      exp_vec = '0; exp_srr0 = '0; exp_srr1 = '0; exp_msr = '0;
      rst_n = 1'b0; raise_vld = '0; raise_code = '0;
      msr = '0; cur_pc = 32'h0000_1000; next_pc = 32'h0000_1004;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 flush", {31'd0, flush_o}, 32'd0);
      chk("R1 fatal", {31'd0, fatal_o}, 32'd0);
      chk("R1 outputs", vector_o | srr0_o | srr1_o | msr_o | {28'd0, taken_num_o}, 32'd0);

      // R2 slot 0 ignored
      msr = 32'h0000_8000;
      raise(0, 5);
      base = n_flush;
      repeat (4) cycle();
      chk("R2 slot 0 ignored", 32'(n_flush - base), 32'd0);

      // R4 masked external/decrementer, trace passes
      msr = 32'h0000_0000;
      b5 = cnt_taken[5]; b9 = cnt_taken[9];
      raise(5, 1); raise(9, 2); raise(13, 0);
      repeat (6) cycle();
      chk("R4 masked not taken", 32'(cnt_taken[5] + cnt_taken[9] - b5 - b9), 32'd0);
      chk("R4 higher trap passes", 32'(cnt_taken[13]), 32'd1);
      msr = 32'h0001_8000;
      repeat (4) cycle();
      chk("R4 external after enable", 32'(cnt_taken[5] - b5), 32'd1);
      chk("R4 decrementer after enable", 32'(cnt_taken[9] - b9), 32'd1);

      // R5 floating-point program trap masked
      msr = 32'h0000_0000;
      b7 = cnt_taken[7];
      raise(7, 0);
      repeat (4) cycle();
      chk("R5 fp program held", 32'(cnt_taken[7] - b7), 32'd0);
      msr = 32'h0000_0100;
      repeat (3) cycle();
      chk("R5 fp program after mode", 32'(cnt_taken[7] - b7), 32'd1);

      // R9 other program causes
      for (int c = 1; c < 4; c++) begin
         msr = 32'hA5A5_0000 | 32'(c);
         raise(7, c);
         repeat (2) cycle();
      end

      // R6 reset with prefix bit
      msr = 32'h0000_0040;
      raise(1, 0);
      repeat (3) cycle();
      chk("R6 reset prefix vector", vector_o, 32'h000F_FD00);

      // R12 machine check with enable off and on
      msr = 32'h0000_0000;
      raise(2, 0);
      repeat (2) cycle();
      msr = 32'h0000_1000;
      raise(2, 0);
      repeat (2) cycle();

      // R13 re-strobe in the taking cycle
      msr = 32'h0000_8000;
      b3 = cnt_taken[3];
      raise(3, 1);
      cycle();
      raise(3, 2);
      repeat (3) cycle();
      chk("R13 retaken once more", 32'(cnt_taken[3] - b3), 32'd2);

      // R8 fetch fault causes
      for (int c = 0; c < 4; c++) begin
         msr = 32'h0000_0F00 | 32'(c << 20);
         cur_pc = 32'h0000_2000 + 32'(c * 8); next_pc = cur_pc + 4;
         raise(4, c);
         repeat (2) cycle();
      end

      // R3 all at once, lowest first
      msr = 32'hFFFF_FFFF;
      for (int i = 1; i < 14; i++) raise(i, 3);
      repeat (16) cycle();

      // random phase
      for (int k = 0; k < 3000; k++) begin
         for (int i = 0; i < NUM; i++)
            if ($urandom % 10 == 0) raise(i, int'($urandom % 6));
         msr = $urandom;
         cur_pc = $urandom & 32'hFFFF_FFFC;
         next_pc = cur_pc + 4;
         cycle();
      end

      // drain everything that can still be taken
      msr = 32'h0000_9900;
      repeat (20) cycle();
      chk("R3 all drained", {16'd0, m_pend}, 32'd0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule